// File: doc/BRIEF.md
# Vertical Interval and Field Detector

This block watches a digitized, active-low composite sync stream and picks out the vertical blanking interval. A free-running clock runs the block. Every low pulse on the sync input is measured in clock cycles and sorted into one of four kinds: half-width equalizing pulses, normal line sync pulses, broad (serrated) vertical pulses, and overlong lows. Runts shorter than a minimum width are treated as noise and thrown away.

The vertical output goes low when the first broad pulse of an interval ends, which is its first serration edge. It returns high when the first equalizing pulse after that ends. If the input instead holds low for a very long time with no serrations, the block issues a fixed-length default vertical pulse. At the first broad pulse, a line-phase counter started by the last normal sync pulse decides field parity. That decision drives an odd/even flag, which only means something for interlaced input. All thresholds are clock counts given as parameters, so the same block can be rescaled for faster scan rates.

Top module: `vsync_field_det`

## Requirements
- R1: After reset, `vsync_n` is high and `field_odd` is low. Both stay that way until an interval is decoded.
- R2: A low pulse's width is the number of clock edges at which `csync_n` is sampled low. Widths are classified with the default parameters as follows: below 2 is a glitch; 2 to 3 is equalizing; 4 to 19 is normal; 20 to 47 is broad; 48 or more is overlong and is ignored.
- R3: While idle, the end of an accepted broad pulse starts the vertical pulse. `vsync_n` goes low after the clock edge that follows the edge that first samples `csync_n` high.
- R4: During an active vertical pulse, the end of the first accepted equalizing pulse returns `vsync_n` high, with the same one-edge latency as R3.
- R5: Broad and normal pulses that arrive while the vertical pulse is active do not end it.
- R6: A low pulse narrower than the minimum width changes neither output. It also does not disturb the vertical state or the line phase.
- R7: While idle, if `csync_n` has been sampled low on 48 consecutive edges, a default vertical pulse starts. `vsync_n` is held low for exactly 40 clock cycles and is then released, even if the input is still low. Other pulses are ignored during this time.
- R8: At the first broad pulse of an interval, parity is decided. The phase is the distance from the last normal pulse's falling edge to the broad pulse's falling edge, modulo the 64-cycle line. A phase within a quarter line of zero sets `field_odd` to 1 (odd); any other phase clears it to 0 (even). The flag updates in the same cycle that `vsync_n` falls.
- R9: A parity decision is made only if a normal pulse has been accepted since the previous decision. At all other times, `field_odd` holds its value, including through default pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csync_n | input | 1 | Sliced composite sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| field_odd | output | 1 | 1 for an odd field, 0 for an even field |

## Verification
The stimulus has three kinds of vertical interval:
- one whose broad pulses start on a whole-line boundary;
- one that starts half a line later;
- one with a normal pulse and a runt inside the active pulse.

A design that measures phase from the wrong edge, or lets a normal pulse end the pulse, would show the wrong parity or a short `vsync_n`. A serration-free interval checks that the default pulse lasts exactly 40 cycles and that the overlong pulse's trailing edge is not taken for a broad pulse. Two back-to-back intervals with no line sync between them check that parity is held rather than re-decided. Runts placed between lines and inside the active pulse would, if accepted, end `vsync_n` early.

// File: rtl/vfd_pkg.sv
package vfd_pkg;

   typedef enum logic [1:0] {
      V_IDLE = 2'd0,
      V_ACT  = 2'd1,
      V_DEF  = 2'd2
   } vstate_t;

   typedef enum logic [1:0] {
      P_OVER  = 2'd0,
      P_EQ    = 2'd1,
      P_NORM  = 2'd2,
      P_BROAD = 2'd3
   } pclass_t;

endpackage

// File: rtl/vfd_edge.sv
module vfd_edge #(
   parameter int IN_STAGES = 1,
   parameter int CNT_W     = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             csync_n,
   output logic             rise,
   output logic             fall,
   output logic [CNT_W-1:0] low_cnt
);
   logic [IN_STAGES-1:0] stg;
   logic                 in_q;
   logic                 in_d;

   generate
      if (IN_STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg <= '1;
            else        stg <= csync_n;
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg <= '1;
            else        stg <= {stg[IN_STAGES-2:0], csync_n};
         end
      end
   endgenerate

   assign in_q = stg[IN_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_d    <= 1'b1;
         low_cnt <= '0;
      end else begin
         in_d <= in_q;
         if (in_q)          low_cnt <= '0;
         else if (!(&low_cnt)) low_cnt <= low_cnt + 1'b1;
      end
   end

   assign rise = in_q & ~in_d;
   assign fall = ~in_q & in_d;
endmodule

// File: rtl/vfd_classify.sv
module vfd_classify
   import vfd_pkg::*;
#(
   parameter int CNT_W     = 10,
   parameter int MIN_W     = 2,
   parameter int EQ_MAX    = 4,
   parameter int BROAD_MIN = 20,
   parameter int LONG_LOW  = 48
) (
   input  logic             rise,
   input  logic [CNT_W-1:0] low_cnt,
   output logic             acc,
   output pclass_t          cls,
   output logic             long_hit
);
   localparam logic [CNT_W-1:0] C_MIN   = CNT_W'(MIN_W);
   localparam logic [CNT_W-1:0] C_EQ    = CNT_W'(EQ_MAX);
   localparam logic [CNT_W-1:0] C_BROAD = CNT_W'(BROAD_MIN);
   localparam logic [CNT_W-1:0] C_LONG  = CNT_W'(LONG_LOW);

   always_comb begin
      acc = rise && (low_cnt >= C_MIN);
      if (low_cnt >= C_LONG)       cls = P_OVER;
      else if (low_cnt >= C_BROAD) cls = P_BROAD;
      else if (low_cnt >= C_EQ)    cls = P_NORM;
      else                         cls = P_EQ;
   end

   assign long_hit = (low_cnt == C_LONG);
endmodule

// File: rtl/vfd_phase.sv
module vfd_phase #(
   parameter int CNT_W    = 10,
   parameter int LINE_LEN = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fall,
   input  logic             norm_acc,
   input  logic [CNT_W-1:0] width,
   input  logic             decide,
   output logic             field_odd
);
   localparam int PH_W = $clog2(LINE_LEN);
   localparam int QTR  = LINE_LEN / 4;
   localparam logic [PH_W-1:0] PH_LAST = PH_W'(LINE_LEN - 1);
   localparam logic [PH_W-1:0] Q_LO    = PH_W'(QTR);
   localparam logic [PH_W-1:0] Q_HI    = PH_W'(LINE_LEN - QTR);

   logic [PH_W-1:0] ph;
   logic [PH_W-1:0] fall_ph;
   logic            seen_norm;
   logic            odd_cand;

   assign odd_cand = (fall_ph < Q_LO) || (fall_ph >= Q_HI);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph        <= '0;
         fall_ph   <= '0;
         seen_norm <= 1'b0;
         field_odd <= 1'b0;
      end else begin
         if (norm_acc)           ph <= PH_W'(width) + PH_W'(1);
         else if (ph == PH_LAST) ph <= '0;
         else                    ph <= ph + 1'b1;

         if (fall) fall_ph <= ph;

         if (norm_acc) begin
            seen_norm <= 1'b1;
         end else if (decide && seen_norm) begin
            field_odd <= odd_cand;
            seen_norm <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/vfd_vfsm.sv
module vfd_vfsm
   import vfd_pkg::*;
#(
   parameter int DEF_W = 40
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    acc,
   input  pclass_t cls,
   input  logic    long_hit,
   output vstate_t st,
   output logic    decide
);
   localparam int TM_W = $clog2(DEF_W + 1);
   localparam logic [TM_W-1:0] TM_INIT = TM_W'(DEF_W - 1);

   logic [TM_W-1:0] tmr;

   assign decide = (st == V_IDLE) && !long_hit && acc && (cls == P_BROAD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= V_IDLE;
         tmr <= '0;
      end else begin
         case (st)
            V_IDLE: begin
               if (long_hit) begin
                  st  <= V_DEF;
                  tmr <= TM_INIT;
               end else if (decide) begin
                  st <= V_ACT;
               end
            end
            V_ACT: begin
               if (acc && (cls == P_EQ)) st <= V_IDLE;
            end
            V_DEF: begin
               if (tmr == '0) st <= V_IDLE;
               else           tmr <= tmr - 1'b1;
            end
            default: st <= V_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/vsync_field_det.sv
module vsync_field_det
   import vfd_pkg::*;
#(
   parameter int IN_STAGES = 1,
   parameter int CNT_W     = 10,
   parameter int MIN_W     = 2,
   parameter int EQ_MAX    = 4,
   parameter int BROAD_MIN = 20,
   parameter int LONG_LOW  = 48,
   parameter int LINE_LEN  = 64,
   parameter int DEF_W     = 40
) (
   input  logic clk,
   input  logic rst_n,
   input  logic csync_n,
   output logic vsync_n,
   output logic field_odd
);
   generate
      if (!(IN_STAGES >= 1 && MIN_W >= 1 && MIN_W < EQ_MAX && EQ_MAX < BROAD_MIN &&
            BROAD_MIN < LONG_LOW && BROAD_MIN < LINE_LEN - 1 && LINE_LEN >= 8 &&
            LONG_LOW < (2 ** CNT_W) - 1 && DEF_W >= 1)) begin : g_bad_cfg
         $error("vsync_field_det: inconsistent parameter set");
      end
   endgenerate

   logic             rise;
   logic             fall;
   logic [CNT_W-1:0] low_cnt;
   logic             acc;
   pclass_t          cls;
   logic             long_hit;
   vstate_t          st;
   logic             decide;
   logic             norm_acc;

   vfd_edge #(.IN_STAGES(IN_STAGES), .CNT_W(CNT_W)) u_edge (
      .clk(clk), .rst_n(rst_n), .csync_n(csync_n),
      .rise(rise), .fall(fall), .low_cnt(low_cnt)
   );

   vfd_classify #(.CNT_W(CNT_W), .MIN_W(MIN_W), .EQ_MAX(EQ_MAX),
                  .BROAD_MIN(BROAD_MIN), .LONG_LOW(LONG_LOW)) u_cls (
      .rise(rise), .low_cnt(low_cnt), .acc(acc), .cls(cls), .long_hit(long_hit)
   );

   vfd_vfsm #(.DEF_W(DEF_W)) u_fsm (
      .clk(clk), .rst_n(rst_n), .acc(acc), .cls(cls), .long_hit(long_hit),
      .st(st), .decide(decide)
   );

   assign norm_acc = acc && (cls == P_NORM);

   vfd_phase #(.CNT_W(CNT_W), .LINE_LEN(LINE_LEN)) u_phase (
      .clk(clk), .rst_n(rst_n), .fall(fall), .norm_acc(norm_acc),
      .width(low_cnt), .decide(decide), .field_odd(field_odd)
   );

   assign vsync_n = (st == V_IDLE);
endmodule

// File: rtl/vfd_checker.sv
module vfd_checker
   import vfd_pkg::*;
#(
   parameter int DEF_W = 40
) (
   input logic    clk,
   input logic    rst_n,
   input vstate_t st,
   input logic    acc,
   input pclass_t cls,
   input logic    long_hit,
   input logic    field_odd
);
   localparam int DC_W = $clog2(DEF_W + 2);
   logic [DC_W-1:0] def_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            def_cnt <= '0;
      else if (st == V_DEF) def_cnt <= def_cnt + 1'b1;
      else                   def_cnt <= '0;
   end

   // R3: entry to the active pulse follows an accepted broad pulse
   p_start_broad_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(st) == V_IDLE && st == V_ACT) |-> $past(acc && cls == P_BROAD));

   // R4: exit from the active pulse follows an accepted equalizing pulse
   p_end_eq_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(st) == V_ACT && st == V_IDLE) |-> $past(acc && cls == P_EQ));

   // R7: default pulse entered only on the long-low count
   p_def_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(st) != V_DEF && st == V_DEF) |-> $past(long_hit));

   // R7: default pulse never exceeds its length
   p_def_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (st == V_DEF) |-> (def_cnt < DC_W'(DEF_W)));

   // R9: field flag changes only on a broad pulse seen while idle
   p_field_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (field_odd != $past(field_odd)) |-> $past(st == V_IDLE && acc && cls == P_BROAD));
endmodule

bind vsync_field_det vfd_checker #(.DEF_W(DEF_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .st(st), .acc(acc), .cls(cls),
   .long_hit(long_hit), .field_odd(field_odd)
);

// File: tb/sim_vsync_field_det.sv
`timescale 1ns/1ps
module sim_vsync_field_det;
   localparam int MIN_W = 2, EQ_MAX = 4, BROAD_MIN = 20, LONG_LOW = 48;
   localparam int LINE = 64, DEF_W = 40;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic csync_n = 1'b1;
   logic vsync_n, field_odd;

   int checks = 0, failures = 0;
   string cur_req = "R1";
   bit done = 1'b0;

   always #5 clk = ~clk;

   vsync_field_det #(.IN_STAGES(1), .CNT_W(10), .MIN_W(MIN_W), .EQ_MAX(EQ_MAX),
      .BROAD_MIN(BROAD_MIN), .LONG_LOW(LONG_LOW), .LINE_LEN(LINE), .DEF_W(DEF_W)) u0 (
      .clk(clk), .rst_n(rst_n), .csync_n(csync_n), .vsync_n(vsync_n), .field_odd(field_odd));

   // behavioural reference: sample index based, one-edge output latency
   int  k = 0, m_low = 0, m_kf = 0, m_norm = 0, m_left = 0, m_state = 0;
   bit  m_prev = 1'b1, m_seen = 1'b0, m_field = 1'b0;
   bit  p_vs = 1'b1, p_field = 1'b0, exp_vs = 1'b1, exp_field = 1'b0;

   always @(posedge clk) begin
      if (!rst_n) begin
         k = 0; m_low = 0; m_kf = 0; m_norm = 0; m_left = 0; m_state = 0;
         m_prev = 1'b1; m_seen = 1'b0; m_field = 1'b0;
         p_vs = 1'b1; p_field = 1'b0; exp_vs = 1'b1; exp_field = 1'b0;
      end else begin
         bit s, rz, dflt;
         int w;
         exp_vs = p_vs; exp_field = p_field;
         s = csync_n; rz = s && (m_low > 0); w = m_low; dflt = (m_low == LONG_LOW);
         if (!s && m_prev) m_kf = k;
         if (m_state == 2) begin
            m_left--;
            if (m_left == 0) m_state = 0;
         end else if (m_state == 0) begin
            if (dflt) begin
               m_state = 2; m_left = DEF_W;
            end else if (rz && w >= BROAD_MIN && w < LONG_LOW) begin
               m_state = 1;
               if (m_seen) begin
                  int d;
                  d = (m_kf - m_norm) % LINE;
                  m_field = (d < LINE/4) || (d >= LINE - LINE/4);
                  m_seen = 1'b0;
               end
            end
         end else begin
            if (rz && w >= MIN_W && w < EQ_MAX) m_state = 0;
         end
         if (rz && w >= EQ_MAX && w < BROAD_MIN) begin
            m_norm = m_kf; m_seen = 1'b1;
         end
         m_low = s ? 0 : m_low + 1;
         m_prev = s; k++;
         p_vs = (m_state == 0); p_field = m_field;
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         checks++;
         if (vsync_n !== exp_vs || field_odd !== exp_field) begin
            failures++;
            $display("FAIL %s cycle compare: vsync_n=%b field_odd=%b expected %b %b",
                     cur_req, vsync_n, field_odd, exp_vs, exp_field);
         end
      end
   end

   task automatic spot(input string req, input logic act, input logic expv, input string what);
      checks++;
      if (act !== expv) begin
         failures++;
         $display("FAIL %s %s: got %b expected %b", req, what, act, expv);
      end
   endtask

   task automatic pls(input int lw, input int per);
      csync_n = 1'b0;
      repeat (lw) @(negedge clk);
      csync_n = 1'b1;
      repeat (per - lw) @(negedge clk);
   endtask

   task automatic lines(input int n);
      for (int i = 0; i < n; i++) pls(6, LINE);
   endtask

   task automatic eqs(input int n);
      for (int i = 0; i < n; i++) pls(3, LINE/2);
   endtask

   task automatic broads(input int n);
      for (int i = 0; i < n; i++) pls(26, LINE/2);
   endtask

   // standard interval, spot checks on start, end and parity
   task automatic vint(input logic exp_odd, input string preq);
      cur_req = "R3";
      eqs(6); broads(6);
      spot("R3", vsync_n, 1'b0, "vsync active after serrations");
      spot(preq, field_odd, exp_odd, "field parity at interval");
      cur_req = "R4";
      eqs(6);
      spot("R4", vsync_n, 1'b1, "vsync released after equalizing");
   endtask

   task automatic run_all();
      repeat (3) @(negedge clk);
      spot("R1", vsync_n, 1'b1, "vsync after reset");
      spot("R1", field_odd, 1'b0, "field after reset");
      rst_n = 1'b1;
      lines(6);
      spot("R1", vsync_n, 1'b1, "vsync idle on plain lines");
      spot("R1", field_odd, 1'b0, "field held before first interval");
      cur_req = "R6";
      for (int i = 0; i < 4; i++) begin pls(6, 30); pls(1, 34); end
      spot("R6", vsync_n, 1'b1, "runts between lines");
      vint(1'b1, "R8");
      lines(6);
      pls(6, 96);
      vint(1'b0, "R8");
      cur_req = "R9";
      vint(1'b0, "R9");
      lines(6);
      cur_req = "R5";
      eqs(6); broads(6);
      pls(6, LINE/2);
      spot("R5", vsync_n, 1'b0, "normal pulse during active");
      spot("R2", field_odd, 1'b1, "whole-line phase is odd");
      pls(1, LINE/2);
      spot("R6", vsync_n, 1'b0, "runt during active");
      eqs(1);
      spot("R4", vsync_n, 1'b1, "first equalizing ends pulse");
      eqs(5);
      lines(6);
      cur_req = "R7";
      csync_n = 1'b0;
      repeat (60) @(negedge clk);
      spot("R7", vsync_n, 1'b0, "default pulse active");
      spot("R9", field_odd, 1'b1, "field held in default");
      repeat (40) @(negedge clk);
      spot("R7", vsync_n, 1'b1, "default pulse timed out");
      repeat (92) @(negedge clk);
      csync_n = 1'b1;
      repeat (20) @(negedge clk);
      spot("R2", vsync_n, 1'b1, "overlong trailing edge ignored");
      lines(6);
      pls(6, 96);
      vint(1'b0, "R8");
      lines(4);
   endtask

   initial begin
      fork
         begin run_all(); end
         begin
            repeat (150000) @(posedge clk);
            failures++;
            $display("FAIL watchdog expired");
         end
      join_any
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule